// File: doc/BRIEF.md
# Inter-Processor Doorbell and Message Interrupt Unit

This block keeps, for every CPU of a cluster, a 32-bit word of pending doorbells and a 32-bit enable word. Doorbells are rung in two ways: a global trigger register write that names one doorbell and a bitmap of target CPUs, and an inbound message-signalled interrupt (MSI) write that arrives on a valid/ready stream and rings one doorbell of CPU 0. Doorbells 0 to 7 act as inter-processor interrupts (IPI) and doorbells 16 to 31 as message interrupts. Each CPU gets two level outputs, one per group, which feed an interrupt router as its sources 0 and 1.

Software acknowledges doorbells by writing the pending word: every bit written as 0 is cleared and every bit written as 1 is kept. Writing the inverse of the handled bits therefore acknowledges exactly those, and writing 0 drops everything. A doorbell rung in the same cycle as a clear of the same bit stays pending. The register port is plain: one write per cycle, and a combinational read of any CPU's pending or enable word.

The MSI stream has no back-pressure: `msi_ready` is high whenever the block is out of reset, so a word is taken on every cycle where `msi_valid` is high after reset. A message and a trigger write in the same cycle are both taken.

Top module: `doorbell_unit`

## Requirements
- R1: While and after reset, every pending word and every enable word is 0, both summary outputs of every CPU are low, and `msi_ready` is high once reset is released.
- R2: A write to offset 0x04 rings doorbell `wr_data[4:0]` on every CPU i with `wr_data[8+i]` = 1, visible one cycle later; other CPUs and other bits are unchanged, and `wr_cpu` plays no part.
- R3: An accepted MSI word whose bits [11:8] equal 0xF rings doorbell `msi_data[4:0]` on CPU 0 only (data 0xF00 | (v + 16) rings doorbell 16 + v).
- R4: An accepted MSI word whose bits [11:8] differ from 0xF changes no pending word.
- R5: A write to offset 0x08 of CPU `wr_cpu` clears each pending bit written as 0 and keeps each bit written as 1; writing 0 clears all of that CPU's pending bits.
- R6: When a doorbell is rung in the same cycle as a clear of the same bit, the bit is pending afterwards.
- R7: A write to offset 0x0C of CPU `wr_cpu` replaces that CPU's enable word.
- R8: `ipi_irq[i]` is high exactly when pending & enable of CPU i is nonzero in bits 7:0.
- R9: `msi_irq[i]` is high exactly when pending & enable of CPU i is nonzero in bits 31:16; bits 15:8 drive neither output.
- R10: `rd_data` shows the pending word of `rd_cpu` for `rd_addr` 0x08, its enable word for 0x0C, and 0 for any other offset, in the same cycle.
- R11: A trigger write and an MSI word in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset of the write |
| wr_cpu | input | 2 | CPU whose private registers are written |
| wr_data | input | 32 | Write data |
| rd_cpu | input | 2 | CPU whose private registers are read |
| rd_addr | input | 8 | Register byte offset of the read |
| rd_data | output | 32 | Read data |
| msi_valid | input | 1 | Inbound message word present |
| msi_ready | output | 1 | Message word accepted when high together with valid |
| msi_data | input | 32 | Inbound message data |
| ipi_irq | output | 4 | Per-CPU summary of enabled pending doorbells 7:0 |
| msi_irq | output | 4 | Per-CPU summary of enabled pending doorbells 31:16 |

## Verification
Trigger writes with sparse and dense CPU bitmaps separate per-CPU routing from a broadcast, and doorbell numbers in the gap 8 to 15 separate the two group summaries from each other and from a plain any-bit-set. Message words with correct and wrong tags tell a tag check from an unconditional ring, while inverse-pattern acknowledges and writes of zero tell clear-on-zero from write-through or clear-on-one. Same-cycle collisions of a message with a clear, and of a message with a trigger write, expose lost events; a random mix of all operations follows the directed cases.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int ADDR_W_DEF = 8;
  localparam logic [7:0] OFS_TRIGGER = 8'h04;
  localparam logic [7:0] OFS_PENDING = 8'h08;
  localparam logic [7:0] OFS_ENABLE  = 8'h0C;
  localparam int DB_W_DEF    = 32;
  localparam logic [31:0] IPI_GROUP = 32'h0000_00FF;
  localparam logic [31:0] MSI_GROUP = 32'hFFFF_0000;
  localparam int MAP_LSB_DEF = 8;
  localparam int TAG_LSB_DEF = 8;
  localparam int TAG_W_DEF   = 4;
  localparam logic [3:0] MSI_TAG = 4'hF;
endpackage

// File: rtl/db_set_decode.sv
module db_set_decode #(
  parameter int NUM_CPUS = 4,
  parameter int DB_W     = 32,
  parameter int MAP_LSB  = 8,
  parameter int TAG_LSB  = 8,
  parameter int TAG_W    = 4,
  parameter logic [TAG_W-1:0] TAG_VAL = '1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           trig_wr,
  input  logic [DB_W-1:0]                trig_data,
  input  logic                           msi_fire,
  input  logic [DB_W-1:0]                msi_data,
  output logic [NUM_CPUS-1:0][DB_W-1:0]  set_vec
);
  localparam int IDX_W = $clog2(DB_W);

  logic [DB_W-1:0] trig_onehot;
  logic [DB_W-1:0] msi_onehot;
  logic            msi_ok;
  logic            unused_bits;

  assign trig_onehot = DB_W'(1) << trig_data[IDX_W-1:0];
  assign msi_onehot  = DB_W'(1) << msi_data[IDX_W-1:0];
  assign msi_ok      = msi_fire && (msi_data[TAG_LSB +: TAG_W] == TAG_VAL);
  assign unused_bits = ^{trig_data, msi_data};

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [DB_W-1:0] from_trig;
    logic [DB_W-1:0] from_msi;
    assign from_trig = (trig_wr && trig_data[MAP_LSB + c]) ? trig_onehot : '0;
    if (c == 0) begin : g_msi_target
      assign from_msi = msi_ok ? msi_onehot : '0;
    end else begin : g_no_msi
      assign from_msi = '0;
    end
    assign set_vec[c] = from_trig | from_msi;

    // R3: a message never rings a CPU other than 0 on its own
    if (c != 0) begin : g_chk
      a_r3_msi_cpu0_only: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_fire && !trig_wr) |-> (set_vec[c] == '0));
    end
  end

  // R4: a message with a wrong tag rings nothing
  a_r4_bad_tag_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_fire && !trig_wr && (msi_data[TAG_LSB +: TAG_W] != TAG_VAL)) |-> (set_vec == '0));

  // R2: a trigger write rings at most one doorbell per CPU
  a_r2_single_bell: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && !msi_fire) |-> ($countones(set_vec) <= NUM_CPUS));
endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank #(
  parameter int DB_W = 32,
  parameter logic [DB_W-1:0] IPI_MASK = 32'h0000_00FF,
  parameter logic [DB_W-1:0] MSI_MASK = 32'hFFFF_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DB_W-1:0] set_vec,
  input  logic            pend_we,
  input  logic            en_we,
  input  logic [DB_W-1:0] wdata,
  output logic [DB_W-1:0] pending,
  output logic [DB_W-1:0] enable,
  output logic            ipi_irq,
  output logic            msi_irq
);
  logic [DB_W-1:0] kept;
  logic [DB_W-1:0] live;

  assign kept = pend_we ? (pending & wdata) : pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      enable  <= '0;
    end else begin
      pending <= kept | set_vec;
      if (en_we) enable <= wdata;
    end
  end

  assign live    = pending & enable;
  assign ipi_irq = |(live & IPI_MASK);
  assign msi_irq = |(live & MSI_MASK);

  // R6: a rung bell survives a same-cycle clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pending & $past(set_vec)) == $past(set_vec)));

  // R5: with no bell rung, a pending write keeps only bits written as 1
  a_r5_clear_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_we && set_vec == '0) |=> (pending == ($past(pending) & $past(wdata))));

  // R5: pending word holds when nothing touches it
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_we && set_vec == '0) |=> $stable(pending));

  // R7: enable word takes the written value
  a_r7_enable_store: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (enable == $past(wdata)));

  // R8: an IPI summary only rises after a bell or an enable change
  a_r8_ipi_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ipi_irq) |-> ($past(set_vec != '0) || $past(en_we)));

  // R9: an MSI summary only rises after a bell or an enable change
  a_r9_msi_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msi_irq) |-> ($past(set_vec != '0) || $past(en_we)));
endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
  import doorbell_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int DB_W     = DB_W_DEF,
  parameter int ADDR_W   = ADDR_W_DEF,
  parameter int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CPU_W-1:0]    wr_cpu,
  input  logic [DB_W-1:0]     wr_data,
  input  logic [CPU_W-1:0]    rd_cpu,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DB_W-1:0]     rd_data,
  input  logic                msi_valid,
  output logic                msi_ready,
  input  logic [DB_W-1:0]     msi_data,
  output logic [NUM_CPUS-1:0] ipi_irq,
  output logic [NUM_CPUS-1:0] msi_irq
);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFS_TRIGGER);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PENDING);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_ENABLE);
  localparam logic [CPU_W:0]    NCPU_L = (CPU_W+1)'(NUM_CPUS);

  logic                          ready_q;
  logic                          trig_wr;
  logic                          msi_fire;
  logic [NUM_CPUS-1:0][DB_W-1:0] set_vec;
  logic [NUM_CPUS-1:0][DB_W-1:0] pend_q;
  logic [NUM_CPUS-1:0][DB_W-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign msi_ready = ready_q;
  assign msi_fire  = msi_valid && ready_q;
  assign trig_wr   = wr_en && (wr_addr == A_TRIG);

  db_set_decode #(
    .NUM_CPUS(NUM_CPUS), .DB_W(DB_W), .MAP_LSB(MAP_LSB_DEF),
    .TAG_LSB(TAG_LSB_DEF), .TAG_W(TAG_W_DEF), .TAG_VAL(MSI_TAG)
  ) u_decode (
    .clk(clk), .rst_n(rst_n),
    .trig_wr(trig_wr), .trig_data(wr_data),
    .msi_fire(msi_fire), .msi_data(msi_data),
    .set_vec(set_vec)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
    logic sel;
    assign sel = (wr_cpu == CPU_W'(c));
    db_cpu_bank #(
      .DB_W(DB_W), .IPI_MASK(DB_W'(IPI_GROUP)), .MSI_MASK(DB_W'(MSI_GROUP))
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .set_vec(set_vec[c]),
      .pend_we(wr_en && sel && (wr_addr == A_PEND)),
      .en_we(wr_en && sel && (wr_addr == A_EN)),
      .wdata(wr_data),
      .pending(pend_q[c]), .enable(en_q[c]),
      .ipi_irq(ipi_irq[c]), .msi_irq(msi_irq[c])
    );
  end

  always_comb begin
    rd_data = '0;
    if ({1'b0, rd_cpu} < NCPU_L) begin
      if (rd_addr == A_PEND)    rd_data = pend_q[rd_cpu];
      else if (rd_addr == A_EN) rd_data = en_q[rd_cpu];
    end
  end

  // R1: nothing is signalled in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ready_q) |-> (ipi_irq == '0 && msi_irq == '0));

  // R11: the stream never back-pressures once out of reset
  a_r11_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> msi_ready);
endmodule

// File: tb/sim_doorbell_unit.sv
`timescale 1ns/1ps
module sim_doorbell_unit;
  localparam int N = 4;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [1:0]  wr_cpu = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_cpu = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        msi_valid = 1'b0;
  logic        msi_ready;
  logic [31:0] msi_data = '0;
  logic [N-1:0] ipi_irq, msi_irq;

  doorbell_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_cpu(wr_cpu),
    .wr_data(wr_data), .rd_cpu(rd_cpu), .rd_addr(rd_addr), .rd_data(rd_data),
    .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_data(msi_data),
    .ipi_irq(ipi_irq), .msi_irq(msi_irq)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] m_pend [N];
  logic [31:0] m_en   [N];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < N; c++) begin
      rd_cpu = 2'(c);
      rd_addr = 8'h08;
      #0.1;
      chk($sformatf("%s R10 pending cpu%0d", tag, c), rd_data, m_pend[c]);
      rd_addr = 8'h0C;
      #0.1;
      chk($sformatf("%s R7 enable cpu%0d", tag, c), rd_data, m_en[c]);
      chk($sformatf("%s R8 ipi cpu%0d", tag, c), 32'(ipi_irq[c]),
          32'(|(m_pend[c] & m_en[c] & 32'h0000_00FF)));
      chk($sformatf("%s R9 msi cpu%0d", tag, c), 32'(msi_irq[c]),
          32'(|(m_pend[c] & m_en[c] & 32'hFFFF_0000)));
    end
  endtask

  // expected effect of one cycle of stimulus, from the requirements
  task automatic model(input logic we, input logic [7:0] a, input logic [1:0] cpu,
                       input logic [31:0] d, input logic mv, input logic [31:0] md);
    for (int c = 0; c < N; c++) begin
      logic [31:0] ring;
      ring = '0;
      if (we && a == 8'h04 && d[8+c]) ring |= 32'(1) << d[4:0];
      if (mv && md[11:8] == 4'hF && c == 0) ring |= 32'(1) << md[4:0];
      if (we && a == 8'h08 && cpu == 2'(c)) m_pend[c] &= d;
      m_pend[c] |= ring;
      if (we && a == 8'h0C && cpu == 2'(c)) m_en[c] = d;
    end
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [1:0] cpu,
                      input logic [31:0] d, input logic mv, input logic [31:0] md);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_cpu = cpu; wr_data = d;
    msi_valid = mv; msi_data = md;
    @(posedge clk);
    #1;
    wr_en = 1'b0; msi_valid = 1'b0;
    model(we, a, cpu, d, mv, md);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    for (int c = 0; c < N; c++) begin m_pend[c] = '0; m_en[c] = '0; end
    seed = $urandom(32'd7193);
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 in reset");
    chk("R1 ready low in reset", 32'(msi_ready), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 msi_ready after reset", 32'(msi_ready), 32'd1);
    check_all("R1 after reset");
    rd_addr = 8'h04; #0.1;
    chk("R10 other offset reads 0", rd_data, 32'd0);

    // R2: doorbell 2 to CPUs 1 and 3, wr_cpu set to 2 to show it is ignored
    step(1, 8'h04, 2'd2, (32'b1010 << 8) | 32'd2, 0, 0);
    check_all("R2 trigger bitmap");
    step(1, 8'h0C, 2'd1, 32'hFFFF_00FF, 0, 0);
    check_all("R8 ipi enabled");
    // R3: vector 5 lands on doorbell 21 of CPU 0
    step(1, 8'h0C, 2'd0, 32'hFFFF_0000, 0, 0);
    step(0, 8'h00, 2'd0, 0, 1, 32'hF00 | (32'd5 + 32'd16));
    check_all("R3 msi vector 5");
    chk("R3 doorbell 21", 32'(m_pend[0][21]), 32'd1);
    // R4: wrong tag
    step(0, 8'h00, 2'd0, 0, 1, 32'hE14);
    check_all("R4 bad tag");
    // R9: doorbell 10 in the gap, then acknowledge 21 by inverse
    step(1, 8'h0C, 2'd0, 32'hFFFF_FFFF, 0, 0);
    step(1, 8'h04, 2'd0, (32'b0001 << 8) | 32'd10, 0, 0);
    step(1, 8'h08, 2'd0, ~(32'd1 << 21), 0, 0);
    check_all("R5 R9 inverse ack gap bit");
    chk("R9 gap bit silent", 32'(msi_irq[0] | ipi_irq[0]), 32'd0);
    // R6: clear all and message on doorbell 31 in one cycle
    step(1, 8'h08, 2'd0, 32'd0, 1, 32'hF1F);
    check_all("R6 set wins");
    chk("R6 bit31 kept", m_pend[0], 32'h8000_0000);
    // R11: trigger and message together
    step(1, 8'h04, 2'd1, (32'b0001 << 8) | 32'd3, 1, 32'hF10);
    check_all("R11 trigger with msi");
    // R5: write 0 clears everything on CPU 1
    step(1, 8'h04, 2'd0, (32'b0010 << 8) | 32'd30, 0, 0);
    step(1, 8'h08, 2'd1, 32'd0, 0, 0);
    check_all("R5 write zero");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] d, md;
      logic [1:0]  cpu;
      logic        mv;
      int          op;
      op  = $urandom_range(0, 3);
      cpu = 2'($urandom_range(0, 3));
      mv  = 1'($urandom_range(0, 1));
      md  = {20'($urandom), ($urandom_range(0, 1) == 1) ? 4'hF : 4'($urandom), 8'($urandom)};
      d   = $urandom;
      if (op == 1 && $urandom_range(0, 1) == 1) d = ~(32'd1 << $urandom_range(0, 31));
      case (op)
        0: step(1, 8'h04, cpu, d, mv, md);
        1: step(1, 8'h08, cpu, d, mv, md);
        2: step(1, 8'h0C, cpu, d, mv, md);
        default: step(0, 8'h00, cpu, d, mv, md);
      endcase
      check_all("R2 R3 R4 R5 R6 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule